// File: doc/BRIEF.md
# Interrupt Enable Shadow Controller

This block decides, at every instruction boundary of a small processor, whether a pending interrupt request may be taken. It owns the processor status register. The global interrupt-enable flag sits in bit 7 of that register. Software can change the register in four ways: a dedicated set-enable instruction, a write in I/O space, a store in data space, or a return-from-interrupt.

A rising edge of the enable flag arms a one-bit shadow register. The edge counts no matter which path produced it. While the shadow bit is set, acceptance is masked for exactly one retired instruction. An instruction that follows an enabling write therefore always completes before any interrupt, even one that was already waiting. Writing 1 into a flag that is already set causes no edge, so no delay is added. Requests are latched per line until their source acknowledges them. When several are pending, the lowest-numbered line is reported as the vector index. Taking an interrupt clears the enable flag.

Top module: `irq_gate_ctrl`

## Requirements
- R1: Reset clears the status register to 0x00, empties all pending requests and clears the shadow bit; `accept_o` is 0 during and after reset until a request is both pending and enabled.
- R2: The enable flag is status bit 7. A set-enable strobe sets bit 7 and leaves bits 6..0 unchanged.
- R3: An I/O write loads the whole status register only when its address equals 0x3F. A write to any other I/O address leaves the register unchanged.
- R4: A data-space store loads the whole status register only when its address equals 0x005F. A store to any other address leaves the register unchanged.
- R5: When bit 7 goes from 0 to 1, by any path, no interrupt is accepted at the retire of the enabling instruction or at the next retire. Acceptance becomes possible from the second retire after the enabling one.
- R6: A write of 1 to bit 7 while bit 7 is already 1 adds no delay. A pending request is accepted at the retire of that same writing instruction.
- R7: `accept_o` is asserted only in a cycle where `retire_i` is 1. Cycles without a retire never accept.
- R8: On acceptance, `vector_o` gives the index of the lowest-numbered pending request.
- R9: Acceptance clears bit 7, so `sreg_o[7]` reads 0 from the next cycle. Bits 6..0 take the value written in the accepting cycle, or keep their value if nothing was written.
- R10: A pulse on `req_i[k]` makes line k pending from the next cycle. The line stays pending until `ack_i[k]` is asserted without `req_i[k]`, which clears it at that clock edge.
- R11: A write of 0 to bit 7 blocks acceptance at the retire of the writing instruction and clears the shadow bit. A later 0-to-1 edge restarts the full one-instruction delay.
- R12: The return-from-interrupt strobe sets bit 7 through the same edge detection, with the same one-instruction delay as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | An instruction completes this cycle (instruction boundary) |
| set_en_i | input | 1 | Dedicated set-enable instruction writes bit 7 to 1 |
| rti_i | input | 1 | Return-from-interrupt sets bit 7 |
| io_we_i | input | 1 | I/O-space write strobe |
| io_addr_i | input | 6 | I/O-space address |
| io_wdata_i | input | 8 | I/O-space write data |
| ds_we_i | input | 1 | Data-space store strobe |
| ds_addr_i | input | 16 | Data-space address |
| ds_wdata_i | input | 8 | Data-space store data |
| req_i | input | 8 | Per-line interrupt request pulses |
| ack_i | input | 8 | Per-line source acknowledge |
| accept_o | output | 1 | Interrupt taken at this boundary |
| vector_o | output | 3 | Index of the accepted request line |
| sreg_o | output | 8 | Current status register |

## Verification
The embedded properties check, on every cycle, a set of invariants. A rising enable flag must arm the shadow bit. A retire must clear an armed shadow bit. Acceptance must never happen off a boundary, with the flag low, or with a clearing I/O write in the same cycle. The reported vector must be the lowest pending line. Acknowledged lines must drop, and unacknowledged lines must hold. Other behaviours depend on a specific ordering of writes, retires and requests over several instructions, so only the bench scenarios can show them. These are the exact count of withheld boundaries after each enabling path, the absence of delay when the flag is rewritten while set, the restart of the delay after a clear, and the rejection of writes to neighbouring addresses.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int SR_W   = 8;
  localparam int EN_BIT = 7;

  typedef logic [SR_W-1:0] sreg_t;

  // Merge all same-cycle status writes: data store over I/O write over set strobes.
  function automatic sreg_t merge_writes(sreg_t cur, logic set_bit,
                                         logic io_hit, sreg_t io_val,
                                         logic ds_hit, sreg_t ds_val);
    sreg_t v;
    v = cur;
    if (set_bit) v[EN_BIT] = 1'b1;
    if (io_hit)  v = io_val;
    if (ds_hit)  v = ds_val;
    return v;
  endfunction
endpackage

// File: rtl/irq_sreg_path.sv
module irq_sreg_path
  import irq_gate_pkg::*;
#(
  parameter int          IO_AW   = 6,
  parameter logic [5:0]  IO_SREG = 6'h3F,
  parameter int          DS_AW   = 16,
  parameter logic [15:0] DS_SREG = 16'h005F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic             set_en_i,
  input  logic             rti_i,
  input  logic             io_we_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  sreg_t            io_wdata_i,
  input  logic             ds_we_i,
  input  logic [DS_AW-1:0] ds_addr_i,
  input  sreg_t            ds_wdata_i,
  input  logic             take_i,
  output sreg_t            sreg_o,
  output logic             open_o,
  output logic             shadow_o,
  output logic             rise_o
);
  sreg_t sreg_q, wr_val, sreg_d;
  logic  shadow_q, shadow_d;
  logic  io_hit, ds_hit;

  assign io_hit = io_we_i && (io_addr_i == IO_SREG[IO_AW-1:0]);
  assign ds_hit = ds_we_i && (ds_addr_i == DS_SREG[DS_AW-1:0]);

  always_comb begin
    wr_val = merge_writes(sreg_q, set_en_i | rti_i, io_hit, io_wdata_i,
                          ds_hit, ds_wdata_i);
    sreg_d = wr_val;
    if (take_i) sreg_d[EN_BIT] = 1'b0;
  end

  assign rise_o = sreg_d[EN_BIT] & ~sreg_q[EN_BIT];

  always_comb begin
    if (rise_o)                          shadow_d = 1'b1;
    else if (!sreg_d[EN_BIT] || retire_i) shadow_d = 1'b0;
    else                                 shadow_d = shadow_q;
  end

  // Open only if the flag was set before, stays set after this cycle's writes, and no shadow.
  assign open_o   = sreg_q[EN_BIT] & wr_val[EN_BIT] & ~shadow_q;
  assign sreg_o   = sreg_q;
  assign shadow_o = shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q   <= '0;
      shadow_q <= 1'b0;
    end else begin
      sreg_q   <= sreg_d;
      shadow_q <= shadow_d;
    end
  end

  a_r5_rise_arms_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sreg_q[EN_BIT]) |-> shadow_q);
  a_r5_retire_drops_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_q && retire_i) |=> !shadow_q);
  a_r11_clear_write_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we_i && io_addr_i == IO_SREG[IO_AW-1:0] && !io_wdata_i[EN_BIT] && !ds_we_i) |-> !open_o);
  a_r9_take_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !sreg_q[EN_BIT]);
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N     = 8,
  localparam int VW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  ack_i,
  output logic [N-1:0]  pend_o,
  output logic          any_o,
  output logic [VW-1:0] vec_o
);
  logic [N-1:0] pend_q;

  // Lowest-numbered set bit wins.
  function automatic logic [VW-1:0] lowest_set(logic [N-1:0] v);
    logic [VW-1:0] idx;
    idx = '0;
    for (int k = N - 1; k >= 0; k--)
      if (v[k]) idx = VW'(k);
    return idx;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack_i) | req_i;
  end

  assign pend_o = pend_q;
  assign any_o  = |pend_q;
  assign vec_o  = lowest_set(pend_q);

  a_r10_ack_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
    |(ack_i & ~req_i) |=> ((pend_q & $past(ack_i & ~req_i)) == '0));
  a_r10_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    |(pend_q & ~ack_i) |=> (($past(pend_q & ~ack_i) & ~pend_q) == '0));
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int          N_REQ   = 8,
  parameter int          IO_AW   = 6,
  parameter logic [5:0]  IO_SREG = 6'h3F,
  parameter int          DS_AW   = 16,
  parameter logic [15:0] DS_SREG = 16'h005F,
  localparam int         VW      = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic             set_en_i,
  input  logic             rti_i,
  input  logic             io_we_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [SR_W-1:0]  io_wdata_i,
  input  logic             ds_we_i,
  input  logic [DS_AW-1:0] ds_addr_i,
  input  logic [SR_W-1:0]  ds_wdata_i,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] ack_i,
  output logic             accept_o,
  output logic [VW-1:0]    vector_o,
  output logic [SR_W-1:0]  sreg_o
);
  logic             gate_open, shadow, en_rise, pend_any;
  logic [N_REQ-1:0] pend;

  irq_sreg_path #(
    .IO_AW(IO_AW), .IO_SREG(IO_SREG), .DS_AW(DS_AW), .DS_SREG(DS_SREG)
  ) u_sreg (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .set_en_i(set_en_i),
    .rti_i(rti_i), .io_we_i(io_we_i), .io_addr_i(io_addr_i),
    .io_wdata_i(io_wdata_i), .ds_we_i(ds_we_i), .ds_addr_i(ds_addr_i),
    .ds_wdata_i(ds_wdata_i), .take_i(accept_o), .sreg_o(sreg_o),
    .open_o(gate_open), .shadow_o(shadow), .rise_o(en_rise)
  );

  irq_pending #(.N(N_REQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i),
    .pend_o(pend), .any_o(pend_any), .vec_o(vector_o)
  );

  assign accept_o = retire_i & gate_open & pend_any;

  a_r7_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> retire_i);
  a_r5_no_accept_in_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (!shadow && sreg_o[EN_BIT] && !en_rise));
  a_r8_lowest_line: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> (pend[vector_o] &&
                  ((pend & ((N_REQ'(1) << vector_o) - N_REQ'(1))) == '0)));
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sreg_o == '0 && !accept_o));
endmodule

// File: tb/test_irq_gate_ctrl.sv
module test_irq_gate_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic retire_i, set_en_i, rti_i, io_we_i, ds_we_i;
  logic [5:0] io_addr_i;
  logic [15:0] ds_addr_i;
  logic [7:0] io_wdata_i, ds_wdata_i, req_i, ack_i, sreg_o;
  logic accept_o;
  logic [2:0] vector_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_gate_ctrl i_irq_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .set_en_i(set_en_i),
    .rti_i(rti_i), .io_we_i(io_we_i), .io_addr_i(io_addr_i),
    .io_wdata_i(io_wdata_i), .ds_we_i(ds_we_i), .ds_addr_i(ds_addr_i),
    .ds_wdata_i(ds_wdata_i), .req_i(req_i), .ack_i(ack_i),
    .accept_o(accept_o), .vector_o(vector_o), .sreg_o(sreg_o)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic ret, sei, rti, iow;
    logic [5:0] ioa;
    logic dsw;
    logic [15:0] dsa;
    logic [7:0] wd, req, ack;
    logic acc;
    logic [2:0] vec;
    logic [7:0] sr;
  } vec_t;

  localparam int NV = 30;
  // rq ret sei rti iow ioa dsw dsa wd req ack acc vec sr(after edge)
  localparam vec_t TBL [NV] = '{
    '{4'd10,1'b0,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h24,8'h00,1'b0,3'd0,8'h00}, // R10 latch
    '{4'd5, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h00}, // R5 disabled
    '{4'd2, 1'b1,1'b1,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h80}, // R2 set-enable
    '{4'd5, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h80}, // R5 shadow
    '{4'd7, 1'b0,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h80}, // R7 no boundary
    '{4'd8, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b1,3'd2,8'h00}, // R8 R9
    '{4'd10,1'b0,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h04,1'b0,3'd0,8'h00}, // R10 ack
    '{4'd3, 1'b1,1'b0,1'b0,1'b1,6'h3F,1'b0,16'h0000,8'h81,8'h00,8'h00,1'b0,3'd0,8'h81}, // R3 io write
    '{4'd5, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h81}, // R5 shadow
    '{4'd8, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b1,3'd5,8'h01}, // R8 R9
    '{4'd10,1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h02,8'h20,1'b0,3'd0,8'h01}, // R10
    '{4'd3, 1'b1,1'b0,1'b0,1'b1,6'h3E,1'b0,16'h0000,8'h80,8'h00,8'h00,1'b0,3'd0,8'h01}, // R3 wrong addr
    '{4'd4, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b1,16'h005F,8'h80,8'h00,8'h00,1'b0,3'd0,8'h80}, // R4 store
    '{4'd5, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h80}, // R5 shadow
    '{4'd6, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b1,16'h005F,8'h82,8'h00,8'h00,1'b1,3'd1,8'h02}, // R6 R9
    '{4'd12,1'b1,1'b0,1'b1,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h02,1'b0,3'd0,8'h82}, // R12 rti
    '{4'd10,1'b0,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h08,8'h00,1'b0,3'd0,8'h82}, // R10
    '{4'd12,1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h82}, // R12 shadow
    '{4'd12,1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b1,3'd3,8'h02}, // R12 accept
    '{4'd2, 1'b1,1'b1,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h82}, // R2 keep low bits
    '{4'd11,1'b1,1'b0,1'b0,1'b1,6'h3F,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h00}, // R11 clear
    '{4'd11,1'b1,1'b1,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h80}, // R11 re-arm
    '{4'd11,1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h80}, // R11 delay
    '{4'd4, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b1,16'h005E,8'h00,8'h00,8'h00,1'b1,3'd3,8'h00}, // R4 wrong addr
    '{4'd2, 1'b1,1'b1,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h80}, // R2
    '{4'd5, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h80}, // R5
    '{4'd11,1'b1,1'b0,1'b0,1'b1,6'h3F,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h00}, // R11 same-boundary block
    '{4'd2, 1'b1,1'b1,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h80}, // R2
    '{4'd5, 1'b1,1'b0,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h00,1'b0,3'd0,8'h80}, // R5
    '{4'd6, 1'b1,1'b1,1'b0,1'b0,6'h00,1'b0,16'h0000,8'h00,8'h00,8'h08,1'b1,3'd3,8'h00}  // R6 sei while set
  };

  task automatic check(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    retire_i = 0; set_en_i = 0; rti_i = 0; io_we_i = 0; ds_we_i = 0;
    io_addr_i = '0; ds_addr_i = '0; io_wdata_i = '0; ds_wdata_i = '0;
    req_i = '0; ack_i = '0;
  endtask

  task automatic apply(vec_t v);
    retire_i = v.ret; set_en_i = v.sei; rti_i = v.rti; io_we_i = v.iow;
    io_addr_i = v.ioa; ds_we_i = v.dsw; ds_addr_i = v.dsa;
    io_wdata_i = v.wd; ds_wdata_i = v.wd; req_i = v.req; ack_i = v.ack;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "sreg in reset", int'(sreg_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    retire_i = 1'b1;
    #1 check("R1", "accept after reset", int'(accept_o), 0);

    // Table walk: drive at negedge, check accept shortly after, sreg one cycle later.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check($sformatf("R%0d", TBL[i-1].rq), "sreg", int'(sreg_o), int'(TBL[i-1].sr));
      apply(TBL[i]);
      #1;
      check($sformatf("R%0d", TBL[i].rq), $sformatf("accept v%0d", i), int'(accept_o), int'(TBL[i].acc));
      if (TBL[i].acc)
        check($sformatf("R%0d", TBL[i].rq), "vector", int'(vector_o), int'(TBL[i].vec));
    end
    @(negedge clk);
    check("R6", "sreg last", int'(sreg_o), int'(TBL[NV-1].sr));
    idle();

    // R1: reset drops pending lines and the flag.
    @(negedge clk); req_i = 8'h80; set_en_i = 1; retire_i = 1;
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1", "sreg after mid reset", int'(sreg_o), 0);
    set_en_i = 1; retire_i = 1;
    @(negedge clk); set_en_i = 0;
    @(negedge clk);
    #1 check("R1", "no stale pending", int'(accept_o), 0);

    // R8: several lines at once, lowest wins.
    @(negedge clk); idle(); req_i = 8'h60;
    @(negedge clk); req_i = '0; retire_i = 1;
    #1 check("R8", "multi pending accept", int'(accept_o), 1);
    check("R8", "multi pending vector", int'(vector_o), 5);
    @(negedge clk); idle();
    check("R9", "flag cleared", int'(sreg_o), 0);
    summary();
  end
endmodule